// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block turns a contact smart card on and off for a host microcontroller. The host pulls an active-low session command low to open a session and raises it again to close it. The block then steps through a fixed power-up order: doubler, supply ramp, I/O lines, card clock, card reset. On close, or when the card is pulled out, it runs the same order in reverse. All timing is counted in cycles of a free-running oscillator. The time unit is T = 64 oscillator cycles, and the sequencer moves in steps of half a unit.

A reset-request input from the host controls the card reset line once activation is complete. During activation it also decides when the card clock starts. If the host holds the request high when the session opens, the clock stays off until the host drops the request. This lets the host count clock pulses exactly before it releases the card from reset. When the session command is high, a status flag tells the host whether a card is inserted.

Top module: `card_power_seq`

## Requirements
- R1: Synchronous reset drives every output low, whatever the other inputs do, and leaves the block idle.
- R2: A session starts only when the command is sampled low, a card is present, and the command has been high at some clock edge since the last session began. The doubler enable rises at the clock edge that samples the start (t1). The ramp enable rises 96 cycles later (1.5T).
- R3: The I/O enable rises 256 cycles after t1 (4T).
- R4: The card reset output stays low until 448 cycles after t1 (7T). From then on it equals the reset request sampled at the previous edge.
- R5: If the reset request is low when the session starts, the card clock enable rises together with the I/O enable.
- R6: If the reset request is high when the session starts, the clock enable stays low until the request is sampled low before t1+7T. It then rises at that same edge, or at t1+4T if the request was dropped earlier.
- R7: From t1+7T onward, the reset request has no effect on the card clock enable.
- R8: When the command is sampled high after full activation (edge D0), outputs turn off in this order: card reset at D0, clock enable at D0+32, I/O enable at D0+64, ramp enable at D0+96, doubler enable at D0+128.
- R9: A command raised during activation counts back from the current step s, where step s is reached 32·s cycles after t1. The doubler drops 32 cycles after D0 if s < 3, 64 cycles after D0 if 3 ≤ s < 8, and 128 cycles after D0 if s ≥ 8.
- R10: Losing card presence during activation or active use starts the same deactivation as raising the command.
- R11: The status flag is registered. While the command is high, the flag equals the presence input. While the command is low, the flag is high only while a session is running or shutting down.
- R12: With no card present, or with the command held low since the previous session, the doubler enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_n | input | 1 | Session command from host, active low |
| rst_req | input | 1 | Reset request from host |
| card_here | input | 1 | Card presence, high when inserted |
| vdbl_en | output | 1 | Voltage doubler enable |
| vramp_en | output | 1 | Card supply ramp enable |
| io_en | output | 1 | I/O and auxiliary line enable |
| cclk_en | output | 1 | Card clock gate enable |
| card_rst | output | 1 | Card reset line |
| host_flag | output | 1 | Presence / session status to host |

## Verification
The assertions assume that the host inputs are synchronous to the oscillator clock and settle before each rising edge. They also assume that reset is asserted for at least one edge before any check counts, so no property samples values from before the first edge. The bench changes every input only on falling edges and keeps reset high for several cycles at the start. It lets the command stay high for a few cycles between sessions so that a new session can start. Presence loss and mid-activation command release are driven at chosen cycle offsets, so every step range of the count-back rule is reached.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_UP, PH_DOWN} phase_e;
  // Count-back steps, in half-T units, reached on deactivation
  localparam int DN_DBL  = 1;
  localparam int DN_RAMP = 2;
  localparam int DN_IO   = 3;
  localparam int DN_CLK  = 4;
endpackage

// File: rtl/card_tbase.sv
module card_tbase #(
  parameter int HALF = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/card_step_seq.sv
module card_step_seq
  import card_seq_pkg::*;
#(
  parameter int SW        = 4,
  parameter int STEP_RAMP = 3,
  parameter int STEP_IO   = 8,
  parameter int STEP_RST  = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          sess_n,
  input  logic          card_here,
  output phase_e        phase_d,
  output logic [SW-1:0] step_d,
  output logic          start,
  output logic          clr
);
  localparam logic [SW-1:0] S_RAMP = SW'(STEP_RAMP);
  localparam logic [SW-1:0] S_IO   = SW'(STEP_IO);
  localparam logic [SW-1:0] S_RST  = SW'(STEP_RST);
  localparam logic [SW-1:0] S_ONE  = SW'(1);

  phase_e        phase_q;
  logic [SW-1:0] step_q;
  logic          armed_q;
  logic          stop;

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    start   = 1'b0;
    stop    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (armed_q && !sess_n && card_here) begin
          start   = 1'b1;
          phase_d = PH_UP;
          step_d  = '0;
        end
      end
      PH_UP: begin
        if (sess_n || !card_here) begin
          stop    = 1'b1;
          phase_d = PH_DOWN;
          if (step_q >= S_IO)        step_d = SW'(DN_CLK);
          else if (step_q >= S_RAMP) step_d = SW'(DN_RAMP);
          else                       step_d = SW'(DN_DBL);
        end else if (tick && step_q != S_RST) begin
          step_d = step_q + 1'b1;
        end
      end
      PH_DOWN: begin
        if (tick) begin
          if (step_q <= S_ONE) begin
            phase_d = PH_IDLE;
            step_d  = '0;
          end else begin
            step_d = step_q - 1'b1;
          end
        end
      end
      default: begin
        phase_d = PH_IDLE;
        step_d  = '0;
      end
    endcase
  end

  assign clr = start | stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      if (sess_n)     armed_q <= 1'b1;
      else if (start) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/card_out_drv.sv
module card_out_drv
  import card_seq_pkg::*;
#(
  parameter int SW        = 4,
  parameter int STEP_RAMP = 3,
  parameter int STEP_IO   = 8,
  parameter int STEP_RST  = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        phase_d,
  input  logic [SW-1:0] step_d,
  input  logic          start,
  input  logic          rst_req,
  input  logic          sess_n,
  input  logic          card_here,
  output logic          vdbl_en,
  output logic          vramp_en,
  output logic          io_en,
  output logic          cclk_en,
  output logic          card_rst,
  output logic          host_flag
);
  localparam logic [SW-1:0] S_RAMP = SW'(STEP_RAMP);
  localparam logic [SW-1:0] S_IO   = SW'(STEP_IO);
  localparam logic [SW-1:0] S_RST  = SW'(STEP_RST);
  localparam logic [SW-1:0] D_RAMP = SW'(DN_RAMP);
  localparam logic [SW-1:0] D_IO   = SW'(DN_IO);
  localparam logic [SW-1:0] D_CLK  = SW'(DN_CLK);

  logic hold_q, hold_d;
  logic dbl_d, ramp_d, io_d, clk_d, crst_d, flag_d;

  always_comb begin
    // Clock hold: latched from the reset request at session start,
    // released only while the sequencer is short of the reset step.
    if (start)                          hold_d = rst_req;
    else if (!rst_req && step_d < S_RST) hold_d = 1'b0;
    else                                hold_d = hold_q;

    dbl_d  = (phase_d != PH_IDLE);
    ramp_d = 1'b0;
    io_d   = 1'b0;
    clk_d  = 1'b0;
    crst_d = 1'b0;
    unique case (phase_d)
      PH_UP: begin
        ramp_d = (step_d >= S_RAMP);
        io_d   = (step_d >= S_IO);
        clk_d  = (step_d >= S_IO) && !hold_d;
        crst_d = (step_d == S_RST) && rst_req;
      end
      PH_DOWN: begin
        ramp_d = (step_d >= D_RAMP);
        io_d   = (step_d >= D_IO);
        clk_d  = cclk_en && (step_d >= D_CLK);
      end
      default: ;
    endcase
    flag_d = sess_n ? card_here : (phase_d != PH_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b0;
      vdbl_en   <= 1'b0;
      vramp_en  <= 1'b0;
      io_en     <= 1'b0;
      cclk_en   <= 1'b0;
      card_rst  <= 1'b0;
      host_flag <= 1'b0;
    end else begin
      hold_q    <= hold_d;
      vdbl_en   <= dbl_d;
      vramp_en  <= ramp_d;
      io_en     <= io_d;
      cclk_en   <= clk_d;
      card_rst  <= crst_d;
      host_flag <= flag_d;
    end
  end
endmodule

// File: rtl/card_power_seq.sv
module card_power_seq
  import card_seq_pkg::*;
#(
  parameter int T_TICKS   = 64,
  parameter int STEP_RAMP = 3,
  parameter int STEP_IO   = 8,
  parameter int STEP_RST  = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic sess_n,
  input  logic rst_req,
  input  logic card_here,
  output logic vdbl_en,
  output logic vramp_en,
  output logic io_en,
  output logic cclk_en,
  output logic card_rst,
  output logic host_flag
);
  localparam int HALF = T_TICKS / 2;
  localparam int SW   = $clog2(STEP_RST + 1);

  logic          tick, clr, start;
  phase_e        phase_d;
  logic [SW-1:0] step_d;

  card_tbase #(.HALF(HALF)) tbase_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .tick (tick)
  );

  card_step_seq #(
    .SW(SW), .STEP_RAMP(STEP_RAMP), .STEP_IO(STEP_IO), .STEP_RST(STEP_RST)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .sess_n    (sess_n),
    .card_here (card_here),
    .phase_d   (phase_d),
    .step_d    (step_d),
    .start     (start),
    .clr       (clr)
  );

  card_out_drv #(
    .SW(SW), .STEP_RAMP(STEP_RAMP), .STEP_IO(STEP_IO), .STEP_RST(STEP_RST)
  ) drv_i (
    .clk       (clk),
    .rst       (rst),
    .phase_d   (phase_d),
    .step_d    (step_d),
    .start     (start),
    .rst_req   (rst_req),
    .sess_n    (sess_n),
    .card_here (card_here),
    .vdbl_en   (vdbl_en),
    .vramp_en  (vramp_en),
    .io_en     (io_en),
    .cclk_en   (cclk_en),
    .card_rst  (card_rst),
    .host_flag (host_flag)
  );
endmodule

// File: rtl/card_power_seq_chk.sv
module card_power_seq_chk (
  input logic clk,
  input logic rst,
  input logic sess_n,
  input logic rst_req,
  input logic card_here,
  input logic vdbl_en,
  input logic vramp_en,
  input logic io_en,
  input logic cclk_en,
  input logic card_rst,
  input logic host_flag
);
  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  AST_RAMP_NEEDS_DBL: assert property (@(posedge clk) disable iff (rst) vramp_en |-> vdbl_en); // R2
  AST_IO_NEEDS_RAMP: assert property (@(posedge clk) disable iff (rst) io_en |-> vramp_en); // R3
  AST_RST_NEEDS_IO: assert property (@(posedge clk) disable iff (rst) card_rst |-> io_en); // R4
  AST_RST_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst) card_rst |-> $past(rst_req)); // R4
  AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (rst) cclk_en |-> io_en); // R5
  AST_CLK_START_PRE_RST: assert property (@(posedge clk) disable iff (rst) $rose(cclk_en) |-> !card_rst); // R7
  AST_STOP_DROPS_RST: assert property (@(posedge clk) disable iff (rst) sess_n |=> !card_rst); // R8
  AST_FLAG_PRESENCE: assert property (@(posedge clk) disable iff (rst) (live_q && $past(sess_n)) |-> (host_flag == $past(card_here))); // R11
  AST_NO_CARD_NO_START: assert property (@(posedge clk) disable iff (rst) (!card_here && !vdbl_en) |=> !vdbl_en); // R12
endmodule

bind card_power_seq card_power_seq_chk chk_i (.*);

// File: tb/card_power_seq_tb_top.sv
`timescale 1ns/1ps
module card_power_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sess_n = 1'b1;
  logic rst_req = 1'b0;
  logic card_here = 1'b1;
  logic vdbl_en, vramp_en, io_en, cclk_en, card_rst, host_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  card_power_seq dut_i (
    .clk(clk), .rst(rst), .sess_n(sess_n), .rst_req(rst_req),
    .card_here(card_here), .vdbl_en(vdbl_en), .vramp_en(vramp_en),
    .io_en(io_en), .cclk_en(cclk_en), .card_rst(card_rst),
    .host_flag(host_flag)
  );

  // Abort offset N (cycles after t1) and count-back step expected (R9)
  localparam int NV = 7;
  localparam int ABORT_TAB [NV][2] = '{
    '{10, 1}, '{95, 1}, '{96, 2}, '{250, 2},
    '{256, 4}, '{300, 4}, '{500, 4}
  };

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic idle_gap(input int n);
    sess_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic count_dbl_off(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (vdbl_en && n < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int fr, fio, fclk, fcrst, n, errs;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", {vdbl_en, vramp_en, io_en, cclk_en, card_rst, host_flag}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 flag idle present", host_flag, 1);

    // Table walk: abort during activation (R9)
    for (int v = 0; v < NV; v++) begin
      rst_req = 1'b0;
      sess_n = 1'b0;
      @(negedge clk);
      chk("R2 doubler at t1", vdbl_en, 1);
      repeat (ABORT_TAB[v][0]) @(negedge clk);
      sess_n = 1'b1;
      count_dbl_off(n);
      chk($sformatf("R9 abort N=%0d off delay", ABORT_TAB[v][0]), n, 32 * ABORT_TAB[v][1] + 1);
      idle_gap(4);
    end

    // Directed A: request low at start (R2 R3 R4 R5 R7 R8)
    fr = -1; fio = -1; fclk = -1; errs = 0;
    rst_req = 1'b0;
    sess_n = 1'b0;
    for (int i = 0; i < 450; i++) begin
      @(negedge clk);
      if (fr < 0 && vramp_en) fr = i;
      if (fio < 0 && io_en) fio = i;
      if (fclk < 0 && cclk_en) fclk = i;
      if (card_rst) errs++;
    end
    chk("R2 ramp delay", fr, 96);
    chk("R3 io delay", fio, 256);
    chk("R5 clock with io", fclk, 256);
    chk("R4 reset held low", errs, 0);
    rst_req = 1'b1;
    @(negedge clk);
    chk("R4 reset follows high", card_rst, 1);
    chk("R7 clock unaffected", cclk_en, 1);
    rst_req = 1'b0;
    @(negedge clk);
    chk("R4 reset follows low", card_rst, 0);
    chk("R7 clock still on", cclk_en, 1);
    rst_req = 1'b1;
    @(negedge clk);
    // Deactivation order (R8)
    sess_n = 1'b1;
    fcrst = -1; fclk = -1; fio = -1; fr = -1; n = -1;
    for (int j = 0; j < 140; j++) begin
      @(negedge clk);
      if (j == 0) chk("R11 flag on stop", host_flag, 1);
      if (fcrst < 0 && !card_rst) fcrst = j;
      if (fclk < 0 && !cclk_en) fclk = j;
      if (fio < 0 && !io_en) fio = j;
      if (fr < 0 && !vramp_en) fr = j;
      if (n < 0 && !vdbl_en) n = j;
    end
    chk("R8 reset off", fcrst, 0);
    chk("R8 clock off", fclk, 32);
    chk("R8 io off", fio, 64);
    chk("R8 ramp off", fr, 96);
    chk("R8 doubler off", n, 128);
    rst_req = 1'b0;
    idle_gap(4);

    // Directed B: request high at start, dropped mid window (R6)
    fclk = -1;
    rst_req = 1'b1;
    sess_n = 1'b0;
    for (int i = 0; i < 311; i++) begin
      @(negedge clk);
      if (fclk < 0 && cclk_en) fclk = i;
      if (i == 300) rst_req = 1'b0;
    end
    chk("R6 clock starts on drop", fclk, 301);
    idle_gap(200);

    // Directed C: request held high through reset enable (R4 R6 R7)
    fclk = -1; fcrst = -1;
    rst_req = 1'b1;
    sess_n = 1'b0;
    for (int i = 0; i < 461; i++) begin
      @(negedge clk);
      if (fclk < 0 && cclk_en) fclk = i;
      if (fcrst < 0 && card_rst) fcrst = i;
    end
    chk("R4 reset enable time", fcrst, 448);
    chk("R6 clock held", fclk, -1);
    rst_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 late drop no clock", cclk_en, 0);
    chk("R4 reset follows drop", card_rst, 0);
    idle_gap(200);

    // Directed D: presence loss (R10 R11 R12)
    sess_n = 1'b0;
    repeat (301) @(negedge clk);
    card_here = 1'b0;
    count_dbl_off(n);
    chk("R10 presence loss off delay", n, 129);
    card_here = 1'b1;
    errs = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (vdbl_en) errs++;
    end
    chk("R12 no restart while held", errs, 0);
    chk("R11 flag low idle cmd low", host_flag, 0);
    sess_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 flag present", host_flag, 1);
    card_here = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 flag absent", host_flag, 0);
    sess_n = 1'b0;
    errs = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (vdbl_en) errs++;
    end
    chk("R12 no card no start", errs, 0);
    sess_n = 1'b1;
    @(negedge clk);
    card_here = 1'b1;
    @(negedge clk);

    // R1: reset during a live session
    sess_n = 1'b0;
    repeat (300) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid session", {vdbl_en, vramp_en, io_en, cclk_en, card_rst}, 0);
    rst = 1'b0;
    idle_gap(4);

    finish_run();
  end
endmodule